// File: doc/BRIEF.md
# Programmable Slave Window Decoder

This block decides whether an incoming bus address falls inside one of two programmable slave windows: one in a 24-bit address space and one in a 32-bit address space. Each access carries a space-select bit that chooses the window to compare. For an address inside the chosen window, the block reports a memory hit and the local offset from the window base. The top longword of each window is reported as a location-monitor strobe instead of a memory hit.

One configuration word holds the base and size of both windows. A sticky ready flag records whether that word has been written since reset. No window responds until that write has happened, and none responds while the global enable input is low. Each window's size is a log2 field. A window has its own legal size range and its own base-alignment rule, and a size encoding outside that range turns the window off. Results are registered and appear one clock after the access is presented. Accesses from the local processor and from the system bus are decoded the same way, with no protection checks.

Top module: `slave_win_decoder`

## Requirements
- R1: `cfg_ready` is 0 after reset. It is 1 from the cycle after the first `cfg_wr` pulse and stays 1 until the next reset.
- R2: While `cfg_ready` is 0, no access produces `mem_hit` or `mon_hit`, even when the reset configuration would match it.
- R3: While `win_en` is low, no access produces `mem_hit` or `mon_hit`.
- R4: Space 0 (`acc_space`=0) selects the 24-bit window, and only `acc_addr[23:0]` is compared. Config bits [4:0] give the base address bits 23:19. Config bits [9:5] hold log2 of the size, legal values 19 to 22. Base bits below the size are treated as zero.
- R5: Space 1 selects the 32-bit window. Config bits [14:10] give the base address bits 31:27. Config bits [19:15] hold log2 of the size, legal values 12 to 27.
- R6: A size field outside a window's legal range means that window never hits.
- R7: On a hit, `offset` equals the address modulo the window size. On a miss it is 0.
- R8: An address in the last 4 bytes of a window gives `mon_hit`=1 and `mem_hit`=0. Any other address inside the window gives `mem_hit`=1 and `mon_hit`=0.
- R9: An access is compared only against the window that `acc_space` selects, so an address inside the other window misses.
- R10: Outputs update on the clock edge after the access is sampled. A cycle with `acc_valid` low gives all-zero outputs.
- R11: The configuration takes the reset value {a32 size 12, a32 base 0, a24 size 19, a24 base 0} after reset. Each write replaces the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 20 | Configuration word (field layout in R4, R5) |
| win_en | input | 1 | Global enable for window response |
| acc_valid | input | 1 | Access present this cycle |
| acc_space | input | 1 | 0 = 24-bit space, 1 = 32-bit space |
| acc_addr | input | 32 | Access address |
| cfg_ready | output | 1 | Configuration has been written since reset |
| mem_hit | output | 1 | Registered ordinary-memory hit |
| mon_hit | output | 1 | Registered location-monitor hit |
| offset | output | 32 | Registered offset inside the hit window |

## Verification
The assertions assume that reset is high on the first clock edge and that every input is a known value at each sampling edge. The bench meets both conditions: it holds reset for several cycles from time zero and drives every input to a defined value at the falling edge. Random addresses are drawn mostly near the programmed window bases and their tops, with some fully random addresses mixed in, so that hits, monitor strobes and misses all occur. Configurations are drawn from both the legal and the illegal size ranges.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int FIELD_W = 5;

    typedef enum logic {
        SPACE_NARROW = 1'b0,
        SPACE_WIDE   = 1'b1
    } space_e;

    // Configuration word: two windows, base field then log2 size field each
    typedef struct packed {
        logic [FIELD_W-1:0] wide_log2;
        logic [FIELD_W-1:0] wide_base;
        logic [FIELD_W-1:0] narrow_log2;
        logic [FIELD_W-1:0] narrow_base;
    } win_cfg_t;

    localparam int CFG_W = $bits(win_cfg_t);

    localparam win_cfg_t CFG_RESET = '{
        wide_log2:   5'd12,
        wide_base:   5'd0,
        narrow_log2: 5'd19,
        narrow_base: 5'd0
    };

    function automatic logic in_range(logic [FIELD_W-1:0] v,
                                      logic [FIELD_W-1:0] lo,
                                      logic [FIELD_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/swd_cfg_reg.sv
module swd_cfg_reg
    import swd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [CFG_W-1:0]   wdata,
    output win_cfg_t           cfg,
    output logic               ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            ready <= 1'b0;
        end else if (wr) begin
            cfg   <= win_cfg_t'(wdata);
            ready <= 1'b1;
        end
    end
endmodule

// File: rtl/swd_window.sv
module swd_window
    import swd_pkg::*;
#(
    parameter int SPACE_W  = 24,
    parameter int MIN_LOG2 = 19,
    parameter int MAX_LOG2 = 22
) (
    input  logic [FIELD_W-1:0] base_field,
    input  logic [FIELD_W-1:0] log2_field,
    input  logic [SPACE_W-1:0] addr,
    output logic               in_win,
    output logic               at_mon,
    output logic [SPACE_W-1:0] win_off
);
    localparam int BASE_LSB = SPACE_W - FIELD_W;
    localparam logic [FIELD_W-1:0] LO = FIELD_W'(MIN_LOG2);
    localparam logic [FIELD_W-1:0] HI = FIELD_W'(MAX_LOG2);
    localparam logic [SPACE_W-1:0] ONE = SPACE_W'(1);
    localparam logic [SPACE_W-1:0] LWORD_LOW = SPACE_W'(3);

    logic               legal;
    logic [SPACE_W-1:0] mask;
    logic [SPACE_W-1:0] base_full;

    always_comb begin
        legal     = in_range(log2_field, LO, HI);
        mask      = legal ? ((ONE << log2_field) - ONE) : '0;
        base_full = '0;
        base_full[SPACE_W-1:BASE_LSB] = base_field;
        in_win    = legal && ((addr & ~mask) == (base_full & ~mask));
        win_off   = in_win ? (addr & mask) : '0;
        at_mon    = in_win && ((win_off | LWORD_LOW) == mask);
    end
endmodule

// File: rtl/slave_win_decoder.sv
module slave_win_decoder
    import swd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NARROW_W    = 24,
    parameter int NARROW_MIN  = 19,
    parameter int NARROW_MAX  = 22,
    parameter int WIDE_MIN    = 12,
    parameter int WIDE_MAX    = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [19:0]       cfg_wdata,
    input  logic              win_en,
    input  logic              acc_valid,
    input  logic              acc_space,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              cfg_ready,
    output logic              mem_hit,
    output logic              mon_hit,
    output logic [ADDR_W-1:0] offset
);
    localparam int NWIN = 2;

    typedef struct packed {
        logic              mem;
        logic              mon;
        logic [ADDR_W-1:0] off;
    } result_t;

    win_cfg_t          cfg;
    logic              ready_q;
    logic [NWIN-1:0]   w_in;
    logic [NWIN-1:0]   w_mon;
    logic [ADDR_W-1:0] w_off [NWIN];
    result_t           res_d, res_q;

    swd_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .ready (ready_q)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam int SW = (i == 0) ? NARROW_W : ADDR_W;
        localparam int LO = (i == 0) ? NARROW_MIN : WIDE_MIN;
        localparam int HI = (i == 0) ? NARROW_MAX : WIDE_MAX;
        logic [SW-1:0] loc_off;
        logic          loc_in, loc_mon;

        swd_window #(.SPACE_W(SW), .MIN_LOG2(LO), .MAX_LOG2(HI)) u_win (
            .base_field (i == 0 ? cfg.narrow_base : cfg.wide_base),
            .log2_field (i == 0 ? cfg.narrow_log2 : cfg.wide_log2),
            .addr       (acc_addr[SW-1:0]),
            .in_win     (loc_in),
            .at_mon     (loc_mon),
            .win_off    (loc_off)
        );

        assign w_in[i]  = loc_in;
        assign w_mon[i] = loc_mon;
        assign w_off[i] = ADDR_W'(loc_off);
    end

    always_comb begin
        logic gate;
        logic sel;
        sel   = (space_e'(acc_space) == SPACE_WIDE);
        gate  = acc_valid && win_en && ready_q && w_in[sel];
        res_d.mem = gate && !w_mon[sel];
        res_d.mon = gate && w_mon[sel];
        res_d.off = gate ? w_off[sel] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign cfg_ready = ready_q;
    assign mem_hit   = res_q.mem;
    assign mon_hit   = res_q.mon;
    assign offset    = res_q.off;
endmodule

// File: rtl/slave_win_decoder_chk.sv
module slave_win_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              win_en,
    input logic              acc_valid,
    input logic              cfg_ready,
    input logic              mem_hit,
    input logic              mon_hit,
    input logic [ADDR_W-1:0] offset
);
    AST_READY_SETS: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr) |-> cfg_ready); // R1
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_ready) |-> cfg_ready); // R1
    AST_QUIET_UNREADY: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_ready) |-> !(mem_hit || mon_hit)); // R2
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !$past(win_en) |-> !(mem_hit || mon_hit)); // R3
    AST_ZERO_OFFSET_MISS: assert property (@(posedge clk) disable iff (rst)
        !(mem_hit || mon_hit) |-> offset == '0); // R7
    AST_MON_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_hit, mon_hit}) <= 1); // R8
    AST_MON_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        mon_hit |-> offset[11:2] == '1); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_valid) |-> !(mem_hit || mon_hit)); // R10
endmodule

bind slave_win_decoder slave_win_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .win_en    (win_en),
    .acc_valid (acc_valid),
    .cfg_ready (cfg_ready),
    .mem_hit   (mem_hit),
    .mon_hit   (mon_hit),
    .offset    (offset)
);

// File: tb/slave_win_decoder_bench.sv
`timescale 1ns/1ps
module slave_win_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic        win_en = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_space = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        cfg_ready, mem_hit, mon_hit;
    logic [31:0] offset;

    int checks = 0;
    int fails  = 0;

    logic [19:0] m_cfg = {5'd12, 5'd0, 5'd19, 5'd0};
    bit          m_rdy = 1'b0;

    always #4 clk = ~clk;

    slave_win_decoder u_slave_win_decoder (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .win_en(win_en), .acc_valid(acc_valid), .acc_space(acc_space),
        .acc_addr(acc_addr), .cfg_ready(cfg_ready), .mem_hit(mem_hit),
        .mon_hit(mon_hit), .offset(offset)
    );

    function automatic logic [19:0] mk(int b24, int n24, int b32, int n32);
        return {5'(n32), 5'(b32), 5'(n24), 5'(b24)};
    endfunction

    function automatic void model(input logic [19:0] c, input bit rdy, input bit en,
                                  input bit v, input bit sp, input logic [31:0] a,
                                  output bit e_mem, output bit e_mon,
                                  output logic [31:0] e_off);
        int n;
        longint base, aa, sz;
        e_mem = 0; e_mon = 0; e_off = '0;
        if (!(v && rdy && en)) return;
        if (!sp) begin
            n = int'(c[9:5]);
            if (n < 19 || n > 22) return;
            base = longint'(c[4:0]) * 524288;
            aa   = longint'(a[23:0]);
        end else begin
            n = int'(c[19:15]);
            if (n < 12 || n > 27) return;
            base = longint'(c[14:10]) * 134217728;
            aa   = longint'(a);
        end
        sz = longint'(1) << n;
        if (aa / sz != base / sz) return;
        e_off = 32'(aa % sz);
        if (aa % sz >= sz - 4) e_mon = 1; else e_mem = 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit v, input bit sp, input logic [31:0] a,
                          input string req);
        bit e_mem, e_mon;
        logic [31:0] e_off;
        acc_valid = v; acc_space = sp; acc_addr = a;
        model(m_cfg, m_rdy, win_en, v, sp, a, e_mem, e_mon, e_off);
        @(posedge clk);
        @(negedge clk);
        check({mem_hit, mon_hit, offset} == {e_mem, e_mon, e_off}, req,
              $sformatf("sp=%0d addr=%h {mem,mon,off}", sp, a),
              {31'b0, mem_hit, mon_hit, offset}, {31'b0, e_mem, e_mon, e_off});
        acc_valid = 1'b0;
    endtask

    task automatic write_cfg(input logic [19:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_cfg = v; m_rdy = 1'b1;
        check(cfg_ready == 1'b1, "R1", "ready after write", 64'(cfg_ready), 64'd1);
    endtask

    initial begin
        #1600000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0123));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(cfg_ready == 0 && mem_hit == 0 && mon_hit == 0 && offset == 0, "R1",
              "reset state", {cfg_ready, mem_hit, mon_hit, offset}, 64'd0);
        // R2: reset config matches address 0 but ready is low
        access(1, 0, 32'h0000_0010, "R2");
        access(1, 1, 32'h0000_0ffc, "R2");
        // R11: reset config in effect after first write of the same value
        write_cfg({5'd12, 5'd0, 5'd19, 5'd0});
        access(1, 0, 32'h0007_fffc, "R11");
        access(1, 1, 32'h0000_0800, "R11");
        // a24 field 5 with 2 MB size -> aligned base 0x200000; a32 base 3, 64 KB
        write_cfg(mk(5, 21, 3, 16));
        access(1, 0, 32'h0020_0000, "R4");
        check(mem_hit == 1 && offset == 0, "R4", "aligned base hit",
              {mem_hit, offset}, {1'b1, 32'h0});
        access(1, 0, 32'hff2a_0010, "R4");
        check(offset == 32'h000a_0010, "R7", "offset upper ignored", 64'(offset), 64'h000a_0010);
        access(1, 0, 32'h003f_fffc, "R8");
        check(mon_hit == 1 && mem_hit == 0, "R8", "monitor top", {mem_hit, mon_hit}, 64'b01);
        access(1, 0, 32'h003f_fffb, "R8");
        access(1, 0, 32'h0040_0000, "R4");
        access(1, 0, 32'h001f_ffff, "R4");
        access(1, 1, 32'h1800_0000, "R5");
        access(1, 1, 32'h1800_fffe, "R8");
        access(1, 1, 32'h1801_0000, "R5");
        access(1, 1, 32'h0020_0004, "R9");
        access(1, 0, 32'h1820_0000, "R9");
        check(mem_hit == 1, "R9", "narrow compare uses low 24 bits", 64'(mem_hit), 64'd1);
        access(0, 0, 32'h0020_0000, "R10");
        win_en = 1'b0;
        access(1, 0, 32'h0020_0000, "R3");
        access(1, 1, 32'h1800_0000, "R3");
        win_en = 1'b1;
        write_cfg(mk(5, 23, 3, 28));
        access(1, 0, 32'h0020_0000, "R6");
        access(1, 1, 32'h1800_0000, "R6");
        write_cfg(mk(0, 18, 0, 11));
        access(1, 0, 32'h0000_0000, "R6");
        access(1, 1, 32'h0000_0000, "R6");
        write_cfg(mk(31, 22, 31, 27));
        access(1, 0, 32'h00ff_fffc, "R8");
        access(1, 1, 32'hffff_ffff, "R8");
        access(1, 1, 32'hf800_0000, "R5");
        // random mix
        for (int it = 0; it < 600; it++) begin
            bit sp;
            logic [31:0] a;
            int n;
            if ($urandom_range(0, 15) == 0)
                write_cfg(mk($urandom_range(0, 31), $urandom_range(17, 24),
                             $urandom_range(0, 31), $urandom_range(10, 29)));
            win_en = ($urandom_range(0, 9) != 0);
            sp = 1'($urandom_range(0, 1));
            a  = $urandom;
            if ($urandom_range(0, 3) != 0) begin
                if (!sp) begin
                    n = int'(m_cfg[9:5]);
                    if (n > 23) n = 23;
                    a = {8'($urandom), m_cfg[4:0], 19'd0};
                    a[23:0] = a[23:0] & ~((24'd1 << n) - 24'd1);
                    if ($urandom_range(0, 1) == 1)
                        a[23:0] = a[23:0] + ((24'd1 << n) - 24'(1 + $urandom_range(0, 7)));
                    else
                        a[23:0] = a[23:0] + 24'($urandom_range(0, 4095));
                end else begin
                    n = int'(m_cfg[19:15]);
                    if (n > 31) n = 31;
                    a = {m_cfg[14:10], 27'd0};
                    a = a & ~((32'd1 << n) - 32'd1);
                    if ($urandom_range(0, 1) == 1)
                        a = a + ((32'd1 << n) - 32'(1 + $urandom_range(0, 7)));
                    else
                        a = a + 32'($urandom_range(0, 4095));
                end
            end
            access(($urandom_range(0, 7) != 0), sp, a,
                   sp ? "R5 R7 R8 R3 R10" : "R4 R7 R8 R3 R10");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule